// File: doc/BRIEF.md
# Program Memory Access Router

This block sits between a processor core and its two on-chip memories. It receives the core's code-space fetch requests and its external-data-space read and write requests. It sends each one to the Flash array or to the XRAM. The Flash size is set by a parameter to 8, 4 or 2 kB. The Flash always starts at address zero inside a 64 kB program space. Its highest byte is the security lock byte. The 512 bytes that end at that byte form the lock page. Every address above the lock byte is unpopulated.

Code fetches always go to Flash. Data-space reads and writes normally go to XRAM. When the redirect enable is set, data-space writes go to the Flash write port instead. The erase select then decides between two operations: erasing the 512-byte page that holds the address, or programming the single addressed byte. Data-space reads still reach XRAM while redirection is on.

All routing outputs and flags are registered, so they appear one clock after the request. A fetch from a reserved address returns 0xFF. The lock and reserved flags only report accesses. Enforcing security is left to the logic outside this block.

Top module: `pmem_router`

## Requirements
- R1: A code read at an address no higher than the Flash top (FLASH_KB*1024-1, 0x1FFF by default) raises flash_rd_en for exactly one cycle, one clock after the request. flash_rd_addr then equals the request address, and code_rdata then carries flash_rdata.
- R2: A code read above the Flash top does not raise flash_rd_en. It raises resv_flag for exactly one cycle, one clock later, and code_rdata then reads 0xFF.
- R3: A data read raises xram_rd_en one clock later with xram_addr equal to the request address. This holds whatever the redirect controls are set to.
- R4: With redir_en low, a data write raises xram_wr_en one clock later with the same address and data. No Flash operation starts and no flag is raised, even when the address lies above the Flash top.
- R5: With redir_en high and redir_erase low, a data write inside Flash raises flash_prog_en one clock later. flash_wr_addr then equals the full request address and flash_wdata equals the request data. xram_wr_en stays low.
- R6: With redir_en high and redir_erase high, a data write inside Flash raises flash_erase_en one clock later. flash_wr_addr then equals the request address with bits 8:0 cleared. flash_prog_en and flash_erase_en are never high together.
- R7: A redirected write above the Flash top starts no Flash operation and no XRAM write. It raises resv_flag for one cycle.
- R8: For a Flash access that is carried out (a code read or a redirected write), two flags are set one clock later. lock_byte_hit is high when the address equals the Flash top. lock_page_hit is high when the address lies between Flash top minus 511 and the Flash top (0x1E00 to 0x1FFF by default). lock_byte_hit never appears without lock_page_hit.
- R9: While rst_n is low at a clock edge, every enable and flag output is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_rd | input | 1 | Code-space read request |
| code_addr | input | 16 | Code-space read address |
| code_rdata | output | 8 | Fetched byte, 0xFF for a reserved address |
| xd_rd | input | 1 | Data-space read request |
| xd_wr | input | 1 | Data-space write request |
| xd_addr | input | 16 | Data-space address |
| xd_wdata | input | 8 | Data-space write data |
| redir_en | input | 1 | Send data-space writes to Flash |
| redir_erase | input | 1 | With redir_en high: 1 erases a page, 0 programs a byte |
| flash_rd_en | output | 1 | Flash read strobe |
| flash_rd_addr | output | 16 | Flash read address |
| flash_rdata | input | 8 | Data returned by the Flash for flash_rd_addr |
| flash_prog_en | output | 1 | Flash byte-program strobe |
| flash_erase_en | output | 1 | Flash page-erase strobe |
| flash_wr_addr | output | 16 | Byte address, or page base when erasing |
| flash_wdata | output | 8 | Byte to program |
| xram_rd_en | output | 1 | XRAM read strobe |
| xram_wr_en | output | 1 | XRAM write strobe |
| xram_addr | output | 16 | XRAM address |
| xram_wdata | output | 8 | XRAM write data |
| resv_flag | output | 1 | One-cycle pulse for an access above the Flash top |
| lock_byte_hit | output | 1 | One-cycle pulse for a Flash access at the lock byte |
| lock_page_hit | output | 1 | One-cycle pulse for a Flash access inside the lock page |

## Verification
The first set of code reads uses addresses chosen around the region boundaries: low Flash, just below the lock page, the lock page base, the lock byte, the first reserved address and the top of the space. This separates the three address classes and shows any off-by-one in the limits. The same data write is then issued with the redirect controls off, in program mode and in erase mode. This shows the XRAM path, the full-address program path and the page-aligned erase path. Reserved-address writes are tried both with and without redirection, and so are reads issued while redirection is on. These cases show that the reserved check applies only to real Flash traffic. A code read and a redirected write issued in the same cycle confirm that the two paths stay independent.

// File: rtl/pmem_pkg.sv
// Shared constants and types for the program memory access router.
// Assumes a 16-bit program space and byte-wide data paths.
package pmem_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int PAGE_BYTES = 512;
    localparam int PAGE_LSB   = $clog2(PAGE_BYTES);

    // Region class of one address
    typedef struct packed {
        logic reserved;
        logic lock_page;
        logic lock_byte;
    } addr_cls_t;

    // Complete routing decision for one cycle of requests
    typedef struct packed {
        logic              code_req;
        logic              code_resv;
        logic              flash_rd;
        logic [ADDR_W-1:0] flash_rd_addr;
        logic              prog;
        logic              erase;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wdata;
        logic              xram_rd;
        logic              xram_wr;
        logic [ADDR_W-1:0] xram_addr;
        logic [DATA_W-1:0] xram_wdata;
        logic              resv;
        logic              lock_byte;
        logic              lock_page;
    } route_t;
endpackage

// File: rtl/pmem_addr_class.sv
// Classifies one program-space address against the Flash layout.
// Assumes the Flash starts at zero, holds at least one page and ends in the lock page.
module pmem_addr_class
    import pmem_pkg::*;
#(
    parameter int FLASH_BYTES = 8192
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_cls_t         cls
);
    localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(FLASH_BYTES - 1);
    localparam logic [ADDR_W-1:0] PAGE_A = ADDR_W'(FLASH_BYTES - PAGE_BYTES);

    // Compare the address with the Flash top and the lock page base
    always_comb begin
        cls.reserved  = (addr > TOP_A);
        cls.lock_byte = (addr == TOP_A);
        cls.lock_page = (addr >= PAGE_A) && (addr <= TOP_A);
    end
endmodule

// File: rtl/pmem_steer.sv
// Combinational routing of code and data-space requests to Flash or XRAM.
// Assumes xd_rd and xd_wr are not raised together.
module pmem_steer
    import pmem_pkg::*;
(
    input  logic              code_rd,
    input  logic [ADDR_W-1:0] code_addr,
    input  addr_cls_t         code_cls,
    input  logic              xd_rd,
    input  logic              xd_wr,
    input  logic [ADDR_W-1:0] xd_addr,
    input  logic [DATA_W-1:0] xd_wdata,
    input  addr_cls_t         xd_cls,
    input  logic              redir_en,
    input  logic              redir_erase,
    output route_t            route
);
    logic redir_wr;
    logic flash_wr_ok;

    // Qualify redirected writes against the reserved region
    always_comb begin
        redir_wr    = xd_wr & redir_en;
        flash_wr_ok = redir_wr & ~xd_cls.reserved;
    end

    // Build the routing decision for this cycle
    always_comb begin
        route               = '0;
        route.code_req      = code_rd;
        route.code_resv     = code_rd & code_cls.reserved;
        route.flash_rd      = code_rd & ~code_cls.reserved;
        route.flash_rd_addr = code_addr;
        route.prog          = flash_wr_ok & ~redir_erase;
        route.erase         = flash_wr_ok & redir_erase;
        route.wr_addr       = redir_erase ? {xd_addr[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}}
                                          : xd_addr;
        route.wdata         = xd_wdata;
        route.xram_rd       = xd_rd;
        route.xram_wr       = xd_wr & ~redir_en;
        route.xram_addr     = xd_addr;
        route.xram_wdata    = xd_wdata;
        route.resv          = (code_rd & code_cls.reserved) | (redir_wr & xd_cls.reserved);
        route.lock_byte     = (code_rd & code_cls.lock_byte) | (flash_wr_ok & xd_cls.lock_byte);
        route.lock_page     = (code_rd & code_cls.lock_page) | (flash_wr_ok & xd_cls.lock_page);
    end
endmodule

// File: rtl/pmem_route_reg.sv
// Output register stage for the routing decision.
// Also keeps whether the most recent code read was reserved, which selects the fetch data.
module pmem_route_reg
    import pmem_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  route_t route_d,
    output route_t route_q,
    output logic   rd_resv_q
);
    // Register the routing decision, clearing everything on reset
    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= '0;
        else        route_q <= route_d;
    end

    // Remember the class of the latest code read for the read-data mux
    always_ff @(posedge clk) begin
        if (!rst_n)                rd_resv_q <= 1'b0;
        else if (route_d.code_req) rd_resv_q <= route_d.code_resv;
    end
endmodule

// File: rtl/pmem_router.sv
// Top of the program memory access router. It classifies both request
// addresses, steers the requests and registers the result.
// Assumes FLASH_KB is 2, 4 or 8 and that the Flash returns data for
// flash_rd_addr within the same cycle.
module pmem_router
    import pmem_pkg::*;
#(
    parameter int FLASH_KB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_rd,
    input  logic [ADDR_W-1:0] code_addr,
    output logic [DATA_W-1:0] code_rdata,
    input  logic              xd_rd,
    input  logic              xd_wr,
    input  logic [ADDR_W-1:0] xd_addr,
    input  logic [DATA_W-1:0] xd_wdata,
    input  logic              redir_en,
    input  logic              redir_erase,
    output logic              flash_rd_en,
    output logic [ADDR_W-1:0] flash_rd_addr,
    input  logic [DATA_W-1:0] flash_rdata,
    output logic              flash_prog_en,
    output logic              flash_erase_en,
    output logic [ADDR_W-1:0] flash_wr_addr,
    output logic [DATA_W-1:0] flash_wdata,
    output logic              xram_rd_en,
    output logic              xram_wr_en,
    output logic [ADDR_W-1:0] xram_addr,
    output logic [DATA_W-1:0] xram_wdata,
    output logic              resv_flag,
    output logic              lock_byte_hit,
    output logic              lock_page_hit
);
    localparam int FLASH_BYTES = FLASH_KB * 1024;
    localparam int N_SRC       = 2;

    logic [ADDR_W-1:0] src_addr [N_SRC];
    addr_cls_t         src_cls  [N_SRC];
    route_t            route_d;
    route_t            route_q;
    logic              rd_resv_q;

    // Collect the two request addresses: 0 is code, 1 is data
    always_comb begin
        src_addr[0] = code_addr;
        src_addr[1] = xd_addr;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_cls
        pmem_addr_class #(.FLASH_BYTES(FLASH_BYTES)) u_cls (
            .addr (src_addr[i]),
            .cls  (src_cls[i])
        );
    end

    pmem_steer u_steer (
        .code_rd     (code_rd),
        .code_addr   (code_addr),
        .code_cls    (src_cls[0]),
        .xd_rd       (xd_rd),
        .xd_wr       (xd_wr),
        .xd_addr     (xd_addr),
        .xd_wdata    (xd_wdata),
        .xd_cls      (src_cls[1]),
        .redir_en    (redir_en),
        .redir_erase (redir_erase),
        .route       (route_d)
    );

    pmem_route_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .route_d   (route_d),
        .route_q   (route_q),
        .rd_resv_q (rd_resv_q)
    );

    // Drive the ports from the registered decision
    always_comb begin
        flash_rd_en    = route_q.flash_rd;
        flash_rd_addr  = route_q.flash_rd_addr;
        flash_prog_en  = route_q.prog;
        flash_erase_en = route_q.erase;
        flash_wr_addr  = route_q.wr_addr;
        flash_wdata    = route_q.wdata;
        xram_rd_en     = route_q.xram_rd;
        xram_wr_en     = route_q.xram_wr;
        xram_addr      = route_q.xram_addr;
        xram_wdata     = route_q.xram_wdata;
        resv_flag      = route_q.resv;
        lock_byte_hit  = route_q.lock_byte;
        lock_page_hit  = route_q.lock_page;
        code_rdata     = rd_resv_q ? {DATA_W{1'b1}} : flash_rdata;
    end
endmodule

// File: rtl/pmem_router_chk.sv
// Property checker for pmem_router, attached by bind.
// Assumes the same FLASH_KB as the bound instance.
module pmem_router_chk
    import pmem_pkg::*;
#(
    parameter int FLASH_KB = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              code_rd,
    input logic [ADDR_W-1:0] code_addr,
    input logic              xd_rd,
    input logic              xd_wr,
    input logic [ADDR_W-1:0] xd_addr,
    input logic              redir_en,
    input logic              flash_rd_en,
    input logic              flash_prog_en,
    input logic              flash_erase_en,
    input logic [ADDR_W-1:0] flash_wr_addr,
    input logic              xram_rd_en,
    input logic              xram_wr_en,
    input logic              resv_flag,
    input logic              lock_byte_hit,
    input logic              lock_page_hit
);
    localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(FLASH_KB * 1024 - 1);

    // R2
    resv_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_rd && code_addr > TOP_A) |=> (!flash_rd_en && resv_flag));

    // R3
    xd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xd_rd |=> xram_rd_en);

    // R4
    xram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xd_wr && !redir_en) |=> (xram_wr_en && !flash_prog_en && !flash_erase_en));

    // R6
    prog_erase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_prog_en && flash_erase_en));

    // R6
    erase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_erase_en |-> (flash_wr_addr[PAGE_LSB-1:0] == '0));

    // R7
    resv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xd_wr && redir_en && xd_addr > TOP_A)
            |=> (!flash_prog_en && !flash_erase_en && !xram_wr_en && resv_flag));

    // R8
    lock_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_byte_hit |-> lock_page_hit);
endmodule

bind pmem_router pmem_router_chk #(.FLASH_KB(FLASH_KB)) u_chk (.*);

// File: tb/test_pmem_router.sv
// Scoreboard bench for pmem_router with the default 8 kB Flash.
module test_pmem_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_rd = 1'b0;
    logic [15:0] code_addr = '0;
    logic [7:0]  code_rdata;
    logic        xd_rd = 1'b0;
    logic        xd_wr = 1'b0;
    logic [15:0] xd_addr = '0;
    logic [7:0]  xd_wdata = '0;
    logic        redir_en = 1'b0;
    logic        redir_erase = 1'b0;
    logic        flash_rd_en;
    logic [15:0] flash_rd_addr;
    logic [7:0]  flash_rdata;
    logic        flash_prog_en, flash_erase_en;
    logic [15:0] flash_wr_addr;
    logic [7:0]  flash_wdata;
    logic        xram_rd_en, xram_wr_en;
    logic [15:0] xram_addr;
    logic [7:0]  xram_wdata;
    logic        resv_flag, lock_byte_hit, lock_page_hit;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string       tag;
        bit          chk_code;
        logic [7:0]  crd;
        logic        frd;
        logic [15:0] fra;
        logic        prog, erase;
        logic [15:0] wa;
        logic [7:0]  wd;
        logic        xrd, xwr;
        logic [15:0] xa;
        logic [7:0]  xwd;
        logic        resv, lb, lp;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    // Flash array model: data is a fixed function of the address
    assign flash_rdata = flash_rd_addr[7:0] ^ 8'hA5;

    pmem_router i_pmem_router (.*);

    // Driver: apply one cycle of requests and push the expected outcome
    task automatic step(string tag, bit crd, logic [15:0] ca, bit xr, bit xw,
                        logic [15:0] xa, logic [7:0] wd, bit wen, bit er);
        exp_t e;
        bit   ok;
        @(negedge clk);
        code_rd = crd; code_addr = ca; xd_rd = xr; xd_wr = xw;
        xd_addr = xa; xd_wdata = wd; redir_en = wen; redir_erase = er;
        ok         = xw && wen && (xa <= 16'h1FFF);
        e.tag      = tag;
        e.chk_code = crd && rst_n;
        e.crd      = (ca <= 16'h1FFF) ? (ca[7:0] ^ 8'hA5) : 8'hFF;
        e.frd      = crd && (ca <= 16'h1FFF);
        e.fra      = ca;
        e.prog     = ok && !er;
        e.erase    = ok && er;
        e.wa       = er ? {xa[15:9], 9'b0} : xa;
        e.wd       = wd;
        e.xrd      = xr;
        e.xwr      = xw && !wen;
        e.xa       = xa;
        e.xwd      = wd;
        e.resv     = (crd && ca > 16'h1FFF) || (xw && wen && xa > 16'h1FFF);
        e.lb       = (e.frd && ca == 16'h1FFF) || (ok && xa == 16'h1FFF);
        e.lp       = (e.frd && ca >= 16'h1E00) || (ok && xa >= 16'h1E00);
        if (!rst_n) begin
            e.frd = 0; e.prog = 0; e.erase = 0; e.xrd = 0; e.xwr = 0;
            e.resv = 0; e.lb = 0; e.lp = 0;
        end
        q.push_back(e);
    endtask

    task automatic idle();
        step("idle", 0, 16'h0, 0, 0, 16'h0, 8'h0, 0, 0);
    endtask

    // Monitor: compare registered outputs just after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            bit   bad;
            e = q.pop_front();
            bad = 0;
            checks++;
            if ({flash_rd_en, flash_prog_en, flash_erase_en, xram_rd_en, xram_wr_en,
                 resv_flag, lock_byte_hit, lock_page_hit} !==
                {e.frd, e.prog, e.erase, e.xrd, e.xwr, e.resv, e.lb, e.lp}) begin
                bad = 1;
                $display("FAIL %s: strobes actual %b expected %b", e.tag,
                    {flash_rd_en, flash_prog_en, flash_erase_en, xram_rd_en, xram_wr_en,
                     resv_flag, lock_byte_hit, lock_page_hit},
                    {e.frd, e.prog, e.erase, e.xrd, e.xwr, e.resv, e.lb, e.lp});
            end
            if (e.frd && flash_rd_addr !== e.fra) begin
                bad = 1;
                $display("FAIL %s: flash_rd_addr actual %h expected %h", e.tag, flash_rd_addr, e.fra);
            end
            if (e.chk_code && code_rdata !== e.crd) begin
                bad = 1;
                $display("FAIL %s: code_rdata actual %h expected %h", e.tag, code_rdata, e.crd);
            end
            if ((e.prog || e.erase) && {flash_wr_addr, flash_wdata} !== {e.wa, e.wd}) begin
                bad = 1;
                $display("FAIL %s: flash write actual %h/%h expected %h/%h", e.tag,
                         flash_wr_addr, flash_wdata, e.wa, e.wd);
            end
            if ((e.xrd || e.xwr) && xram_addr !== e.xa) begin
                bad = 1;
                $display("FAIL %s: xram_addr actual %h expected %h", e.tag, xram_addr, e.xa);
            end
            if (e.xwr && xram_wdata !== e.xwd) begin
                bad = 1;
                $display("FAIL %s: xram_wdata actual %h expected %h", e.tag, xram_wdata, e.xwd);
            end
            if (bad) fails++;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9: requests during reset produce no activity
        step("R9 reset idle", 0, 16'h0, 0, 0, 16'h0, 8'h0, 0, 0);
        step("R9 reset with requests", 1, 16'h0010, 1, 1, 16'h0020, 8'h11, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        idle();
        // R1: code reads inside Flash
        step("R1 code read low", 1, 16'h0123, 0, 0, 16'h0, 8'h0, 0, 0);
        step("R1 code read below lock page", 1, 16'h1DFF, 0, 0, 16'h0, 8'h0, 0, 0);
        idle();
        // R8: lock page base and lock byte
        step("R8 lock page base", 1, 16'h1E00, 0, 0, 16'h0, 8'h0, 0, 0);
        step("R8 lock byte", 1, 16'h1FFF, 0, 0, 16'h0, 8'h0, 0, 0);
        // R2: reserved code reads, with one-cycle flag
        step("R2 first reserved", 1, 16'h2000, 0, 0, 16'h0, 8'h0, 0, 0);
        idle();
        step("R2 top of space", 1, 16'hFFFF, 0, 0, 16'h0, 8'h0, 0, 0);
        step("R1 read after reserved", 1, 16'h0042, 0, 0, 16'h0, 8'h0, 0, 0);
        // R3: data reads with and without redirection
        step("R3 read plain", 0, 16'h0, 1, 0, 16'h3456, 8'h0, 0, 0);
        step("R3 read while redirected", 0, 16'h0, 1, 0, 16'h0100, 8'h0, 1, 1);
        // R4: plain data writes, including a high address
        step("R4 xram write", 0, 16'h0, 0, 1, 16'h0040, 8'h5C, 0, 0);
        step("R4 xram write high addr", 0, 16'h0, 0, 1, 16'h9000, 8'hC3, 0, 1);
        // R5: byte program
        step("R5 program", 0, 16'h0, 0, 1, 16'h1234, 8'h7E, 1, 0);
        idle();
        // R6: page erase, inside the lock page so R8 also applies
        step("R6 erase lock page", 0, 16'h0, 0, 1, 16'h1E77, 8'h00, 1, 1);
        step("R6 erase low page", 0, 16'h0, 0, 1, 16'h03FF, 8'h00, 1, 1);
        step("R8 program lock byte", 0, 16'h0, 0, 1, 16'h1FFF, 8'hA0, 1, 0);
        // R7: redirected writes to reserved space
        step("R7 program reserved", 0, 16'h0, 0, 1, 16'h2000, 8'h12, 1, 0);
        step("R7 erase reserved", 0, 16'h0, 0, 1, 16'hF1FF, 8'h12, 1, 1);
        // R1 R5: code read and redirected write in the same cycle
        step("R1 R5 concurrent", 1, 16'h0777, 0, 1, 16'h0555, 8'h3C, 1, 0);
        idle();
        idle();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule